// File: doc/BRIEF.md
# Two-Level Page Translator with Translation Cache

The block turns a 32-bit linear address into a physical address. It holds a 32-entry cache of recent translations. When paging is enabled and the cache has no entry for the page, a hardware walker reads a page directory and then a page table through a 32-bit memory read port. The walk starts from a 4 KB-aligned root register. When paging is disabled, the linear address is passed through unchanged and no memory is touched.

A client offers one translation at a time with a valid/ready handshake. The block answers with a one-cycle response pulse that carries either a physical address or a not-present fault. Memory reads use a one-cycle request pulse. The matching data comes back after any number of cycles, marked by a valid strobe. A flush input discards every cached translation in a single cycle. Software uses it after it changes the tables or the root.

Top module: `page_xlate_top`

## Requirements
- R1: When `paging_en` is 0 at acceptance, `rsp_phys` equals the accepted `req_lin`, `rsp_fault` is 0, and no memory read is issued. The response arrives on the second clock edge after the accepting edge.
- R2: The linear address is split into three fields. Bits 31:22 form the directory index, bits 21:12 form the table index, and bits 11:0 form the byte offset within the page.
- R3: The first read of a walk goes to `{root_base[31:12], 12'h000} + 4 * directory_index`. The low 12 bits of the root are ignored.
- R4: The second read of a walk goes to `{dir_entry[31:12], 12'h000} + 4 * table_index`.
- R5: A successful walk returns `{table_entry[31:12], offset}`.
- R6: Bit 0 of a directory or table entry is the present flag. If it is 0 at either level, the response has `rsp_fault`=1 and `rsp_phys`=0, and nothing is cached. A repeat of the same address walks again.
- R7: An address whose page is cached returns the cached frame with the offset. It issues no memory read and responds on the second edge after acceptance, even if the tables have since changed.
- R8: The cache holds 32 translations. On a miss with no free slot, the entry used least recently, by either a hit or a fill, is replaced.
- R9: A one-cycle `flush` pulse invalidates every cached translation, so the next access to any page walks memory.
- R10: `req_ready` stays low from acceptance until the response. Each memory read is a one-cycle `mem_req` pulse. The walker waits any number of cycles for `mem_rvalid`.
- R11: `rsp_valid` is a one-cycle pulse per accepted request, and `rsp_fault` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Translation enable, sampled at acceptance |
| root_base | input | 32 | Directory root address, low 12 bits ignored |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Not-present fault |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bound checker watches the handshake on every cycle. It checks that there is only one request in flight, that reads and responses are single-cycle pulses, that faults appear only with a response and carry a zero address, that memory addresses are word-aligned, and that bypass returns the linear address without touching memory. Several properties can only be shown by the bench's scenarios against its behavioural model: the exact walk addresses, which translations stay cached under least-recently-used replacement, the stale-hit-then-flush sequence, and the non-caching of faults.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int LA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int PPN_W    = LA_W - OFF_W;
    localparam int VPN_W    = 2 * IDX_W;
    localparam int ENT_W    = 32;
    localparam int CACHE_N  = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DIR_RD,
        ST_DIR_WT,
        ST_TBL_RD,
        ST_TBL_WT
    } walk_st_e;

    typedef struct packed {
        logic [IDX_W-1:0] dir;
        logic [IDX_W-1:0] tbl;
        logic [OFF_W-1:0] off;
    } lin_addr_t;

    // frame base plus four bytes per index
    function automatic logic [LA_W-1:0] entry_addr(input logic [PPN_W-1:0] frame,
                                                   input logic [IDX_W-1:0] idx);
        return {frame, idx, 2'b00};
    endfunction

    function automatic logic entry_present(input logic [ENT_W-1:0] e);
        return e[0];
    endfunction
endpackage

// File: rtl/pt_lru.sv
module pt_lru #(
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid,
    input  logic          touch_en,
    input  logic [AW-1:0] touch_idx,
    output logic [AW-1:0] victim
);
    logic [AW-1:0] age_q [N];
    logic [AW-1:0] free_idx, old_idx;
    logic          have_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (touch_idx == AW'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx  = AW'(i);
                have_free = 1'b1;
            end
        end
        old_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == AW'(N - 1)) old_idx = AW'(i);
        end
        victim = have_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/pt_tlb.sv
module pt_tlb #(
    parameter int N      = 32,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 20,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              touch_en,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data
);
    logic [N-1:0]        valid_q;
    logic [TAG_W-1:0]    tag_q  [N];
    logic [DATA_W-1:0]   data_q [N];
    logic [N-1:0]        hit_vec;
    logic [IW-1:0]       lk_idx, victim, lru_idx;
    logic                lru_touch;

    generate
        for (genvar g = 0; g < N; g++) begin : g_match
            assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
        end
    endgenerate

    always_comb begin
        lk_hit  = 1'b0;
        lk_idx  = '0;
        lk_data = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                lk_hit  = 1'b1;
                lk_idx  = IW'(i);
                lk_data = data_q[i];
            end
        end
    end

    assign lru_touch = !flush && (fill_en || touch_en);
    assign lru_idx   = fill_en ? victim : lk_idx;

    always_ff @(posedge clk) begin
        if (rst || flush) valid_q <= '0;
        else if (fill_en) valid_q[victim] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[victim]  <= lk_tag;
            data_q[victim] <= fill_data;
        end
    end

    pt_lru #(.N(N)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .valid     (valid_q),
        .touch_en  (lru_touch),
        .touch_idx (lru_idx),
        .victim    (victim)
    );
endmodule

// File: rtl/pt_walk.sv
module pt_walk
    import pt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             paging_en,
    input  logic [LA_W-1:0]  root_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LA_W-1:0]  req_lin,
    output logic             rsp_valid,
    output logic [LA_W-1:0]  rsp_phys,
    output logic             rsp_fault,
    output logic             mem_req,
    output logic [LA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic [VPN_W-1:0] lk_tag,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             touch_en,
    output logic             fill_en,
    output logic [PPN_W-1:0] fill_ppn
);
    walk_st_e         st_q;
    lin_addr_t        cur_q;
    logic             bypass_q;
    logic [PPN_W-1:0] frame_q;
    logic             rsp_v_q, rsp_f_q;
    logic [LA_W-1:0]  rsp_p_q;
    logic             rd_ok;

    assign rd_ok     = entry_present(mem_rdata);
    assign req_ready = (st_q == ST_IDLE);
    assign mem_req   = (st_q == ST_DIR_RD) || (st_q == ST_TBL_RD);
    assign mem_addr  = (st_q == ST_TBL_RD) ? entry_addr(frame_q, cur_q.tbl)
                                           : entry_addr(root_base[LA_W-1:OFF_W], cur_q.dir);
    assign lk_tag    = {cur_q.dir, cur_q.tbl};
    assign touch_en  = (st_q == ST_CHECK) && !bypass_q && lk_hit;
    assign fill_en   = (st_q == ST_TBL_WT) && mem_rvalid && rd_ok;
    assign fill_ppn  = mem_rdata[ENT_W-1:OFF_W];

    assign rsp_valid = rsp_v_q;
    assign rsp_fault = rsp_f_q;
    assign rsp_phys  = rsp_p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cur_q    <= '0;
            bypass_q <= 1'b0;
            frame_q  <= '0;
            rsp_v_q  <= 1'b0;
            rsp_f_q  <= 1'b0;
            rsp_p_q  <= '0;
        end else begin
            rsp_v_q <= 1'b0;
            rsp_f_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_q    <= lin_addr_t'(req_lin);
                        bypass_q <= !paging_en;
                        st_q     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (bypass_q) begin
                        rsp_v_q <= 1'b1;
                        rsp_p_q <= LA_W'(cur_q);
                        st_q    <= ST_IDLE;
                    end else if (lk_hit) begin
                        rsp_v_q <= 1'b1;
                        rsp_p_q <= {lk_ppn, cur_q.off};
                        st_q    <= ST_IDLE;
                    end else begin
                        st_q <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD: st_q <= ST_DIR_WT;
                ST_DIR_WT: begin
                    if (mem_rvalid) begin
                        if (!rd_ok) begin
                            rsp_v_q <= 1'b1;
                            rsp_f_q <= 1'b1;
                            rsp_p_q <= '0;
                            st_q    <= ST_IDLE;
                        end else begin
                            frame_q <= mem_rdata[ENT_W-1:OFF_W];
                            st_q    <= ST_TBL_RD;
                        end
                    end
                end
                ST_TBL_RD: st_q <= ST_TBL_WT;
                ST_TBL_WT: begin
                    if (mem_rvalid) begin
                        rsp_v_q <= 1'b1;
                        st_q    <= ST_IDLE;
                        if (!rd_ok) begin
                            rsp_f_q <= 1'b1;
                            rsp_p_q <= '0;
                        end else begin
                            rsp_p_q <= {mem_rdata[ENT_W-1:OFF_W], cur_q.off};
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
    import pt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             paging_en,
    input  logic [31:0]      root_base,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_lin,
    output logic             rsp_valid,
    output logic [31:0]      rsp_phys,
    output logic             rsp_fault,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata
);
    logic [VPN_W-1:0] lk_tag;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic             touch_en;
    logic             fill_en;
    logic [PPN_W-1:0] fill_ppn;

    pt_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .paging_en  (paging_en),
        .root_base  (root_base),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_lin    (req_lin),
        .rsp_valid  (rsp_valid),
        .rsp_phys   (rsp_phys),
        .rsp_fault  (rsp_fault),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn),
        .touch_en   (touch_en),
        .fill_en    (fill_en),
        .fill_ppn   (fill_ppn)
    );

    pt_tlb #(.N(CACHE_N), .TAG_W(VPN_W), .DATA_W(PPN_W)) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_data   (lk_ppn),
        .touch_en  (touch_en),
        .fill_en   (fill_en),
        .fill_data (fill_ppn)
    );
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        paging_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_lin,
    input logic        rsp_valid,
    input logic [31:0] rsp_phys,
    input logic        rsp_fault,
    input logic        mem_req,
    input logic [31:0] mem_addr
);
    // R10
    one_inflight_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R10
    mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R11
    fault_qual_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid);

    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_phys == 32'h0));

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R1
    bypass_nomem_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !paging_en) |=> !mem_req);

    // R1
    bypass_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !paging_en) |=> ##1
            (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin, 2)));
endmodule

bind page_xlate_top pt_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .paging_en (paging_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_lin   (req_lin),
    .rsp_valid (rsp_valid),
    .rsp_phys  (rsp_phys),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr)
);

// File: tb/tb_page_xlate_top.sv
`timescale 1ns/1ps
module tb_page_xlate_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        paging_en = 1'b0;
    logic [31:0] root_base = 32'h0001_0ABC;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit txn_open = 0;

    always #2.5 clk = ~clk;

    page_xlate_top dut (.*);

    // memory image and responder
    logic [31:0] mem [int unsigned];
    logic [31:0] seen_q [$];
    int          countdown = 0;
    int          lat_sel = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (countdown > 0) begin
            countdown = countdown - 1;
            if (countdown == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd(pend_addr);
            end
        end
        if (mem_req) begin
            pend_addr = mem_addr;
            seen_q.push_back(mem_addr);
            lat_sel   = (lat_sel % 5) + 1;
            countdown = lat_sel;
        end
        if (!txn_open && (rsp_valid || mem_req)) begin
            checks++; failures++;
            $display("FAIL R11 activity outside a request rsp_valid=%0b mem_req=%0b expected 0/0",
                     rsp_valid, mem_req);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model: most-recent-first list of cached pages
    logic [19:0] recent_q [$];
    logic [19:0] model_ppn [int unsigned];

    function automatic logic [31:0] root_dir_addr(input logic [9:0] d);
        return {root_base[31:12], 12'h000} + 32'(d) * 4;
    endfunction

    task automatic map_page(input logic [19:0] vpn, input logic [19:0] ppn);
        logic [31:0] da, ta;
        da = root_dir_addr(vpn[19:10]);
        if (!mem.exists(da)) mem[da] = (32'h0100_0000 + 32'(vpn[19:10]) * 32'h1000) | 32'h1;
        ta = {mem[da][31:12], 12'h000} + 32'(vpn[9:0]) * 4;
        mem[ta] = {ppn, 12'h001};
    endtask

    task automatic do_flush();
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        recent_q.delete();
    endtask

    task automatic xlate(input logic [31:0] lin, input logic en, input string tag);
        logic [31:0] exp_phys, a1, a2, pde, pte;
        logic        exp_fault = 1'b0;
        logic [31:0] exp_rd [$];
        int          found = -1;
        int          cyc;
        logic [19:0] vpn = lin[31:12];
        if (!en) begin
            exp_phys = lin;
        end else begin
            foreach (recent_q[i]) if (recent_q[i] == vpn && found < 0) found = i;
            if (found >= 0) begin
                recent_q.delete(found);
                recent_q.push_front(vpn);
                exp_phys = {model_ppn[vpn], lin[11:0]};
            end else begin
                a1 = root_dir_addr(lin[31:22]);
                pde = rd(a1);
                exp_rd.push_back(a1);
                if (!pde[0]) begin
                    exp_fault = 1'b1; exp_phys = 32'h0;
                end else begin
                    a2 = {pde[31:12], 12'h000} + 32'(lin[21:12]) * 4;
                    pte = rd(a2);
                    exp_rd.push_back(a2);
                    if (!pte[0]) begin
                        exp_fault = 1'b1; exp_phys = 32'h0;
                    end else begin
                        exp_phys = {pte[31:12], lin[11:0]};
                        model_ppn[vpn] = pte[31:12];
                        recent_q.push_front(vpn);
                        if (recent_q.size() > 32) void'(recent_q.pop_back());
                    end
                end
            end
        end
        seen_q.delete();
        @(negedge clk);
        txn_open  = 1;
        paging_en = en;
        req_lin   = lin;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid, tag, "response seen", 32'(rsp_valid), 32'h1);
        chk(rsp_fault == exp_fault, tag, "fault flag", 32'(rsp_fault), 32'(exp_fault));
        chk(rsp_phys == exp_phys, tag, "physical address", rsp_phys, exp_phys);
        chk(seen_q.size() == exp_rd.size(), "R10", "memory read count",
            32'(seen_q.size()), 32'(exp_rd.size()));
        foreach (exp_rd[i]) begin
            if (i < seen_q.size()) begin
                if (i == 0) chk(seen_q[i] == exp_rd[i], "R3", "directory read address", seen_q[i], exp_rd[i]);
                else        chk(seen_q[i] == exp_rd[i], "R4", "table read address", seen_q[i], exp_rd[i]);
            end
        end
        if (exp_rd.size() == 0)
            chk(cyc == 2, en ? "R7" : "R1", "response latency", 32'(cyc), 32'd2);
        @(negedge clk);
        chk(!rsp_valid, "R11", "response pulse width", 32'(rsp_valid), 32'h0);
        txn_open = 0;
    endtask

    initial begin
        #(200000 * 5);
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R10", "ready after reset", 32'(req_ready), 32'h1);
        chk(!rsp_valid && !mem_req, "R11", "quiet after reset",
            {30'h0, rsp_valid, mem_req}, 32'h0);

        // bypass
        xlate(32'h1234_5678, 1'b0, "R1");
        xlate(32'hFFFF_F000, 1'b0, "R1");

        // set up tables
        map_page({10'd3, 10'h2A5}, 20'hABCDE);
        map_page({10'd3, 10'h001}, 20'h00100);
        map_page({10'd5, 10'h3FF}, 20'h55555);
        mem[{mem[root_dir_addr(10'd5)][31:12], 12'h000} + 32'h8] = 32'h1234_5000; // not present

        xlate({10'd3, 10'h2A5, 12'hABC}, 1'b1, "R2");
        xlate({10'd3, 10'h2A5, 12'h123}, 1'b1, "R7");
        xlate({10'd3, 10'h001, 12'hFFF}, 1'b1, "R5");
        xlate({10'd5, 10'h3FF, 12'h000}, 1'b1, "R5");
        xlate({10'h200, 10'h000, 12'h010}, 1'b1, "R6");
        xlate({10'h200, 10'h000, 12'h010}, 1'b1, "R6");
        xlate({10'd5, 10'h002, 12'h444}, 1'b1, "R6");
        xlate({10'd5, 10'h002, 12'h444}, 1'b1, "R6");
        xlate({10'd3, 10'h2A5, 12'h777}, 1'b0, "R1");

        // stale entry stays until flush
        map_page({10'd3, 10'h2A5}, 20'h0F0F0);
        xlate({10'd3, 10'h2A5, 12'h001}, 1'b1, "R7");
        do_flush();
        xlate({10'd3, 10'h2A5, 12'h001}, 1'b1, "R9");
        xlate({10'd3, 10'h001, 12'h002}, 1'b1, "R9");

        // replacement order
        do_flush();
        for (int k = 0; k < 33; k++) map_page(20'h40000 + 20'(k), 20'h80000 + 20'(k));
        for (int k = 0; k < 32; k++) xlate({20'h40000 + 20'(k), 12'h0}, 1'b1, "R8");
        xlate({20'h40000, 12'h004}, 1'b1, "R8");
        xlate({20'h40020, 12'h008}, 1'b1, "R8");
        xlate({20'h40000, 12'h00C}, 1'b1, "R8");
        xlate({20'h40001, 12'h010}, 1'b1, "R8");
        xlate({20'h40002, 12'h014}, 1'b1, "R8");
        xlate({20'h40020, 12'h018}, 1'b1, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule